// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block converts one host register access into a complete cycle on an external 8-bit bus. That bus carries the address and the data on the same eight lines, one after the other. The host raises a one-cycle request together with a direction flag, an address and write data. The block then works through four timed phases: address, turnaround, strobe and hold. When the last phase ends it returns a done pulse, and for a read it also returns the data it captured from the bus.

On the bus side there are three strobes. A latch-enable strobe marks the address phase, and separate read and write strobes mark the data transfer. The AD lines are split into an output value, an output enable and an input value, so that the tri-state buffer can sit at the pad. Each strobe's active level comes from its own polarity input. A strobe can also be switched off entirely, in which case it stays at its idle level and never toggles. A read-only or write-only system can therefore leave that pin unused. The length of each phase is a parameter counted in clock cycles.

Top module: `adbus_master`

## Requirements
- R1: After reset the latch strobe is at its asserted level, the read and write strobes are at their deasserted levels, AD drives 0x00 with ad_oe high, and busy and done are low.
- R2: A request sampled high while idle starts a cycle. For the next ADDR_CYC cycles busy is high, the latch strobe stays asserted and AD drives the request address with ad_oe high.
- R3: For the TURN_CYC cycles after the address phase, the latch strobe is deasserted and neither the read nor the write strobe is asserted.
- R4: In a write cycle (wr_nrd = 1) the write strobe is asserted for PULSE_CYC cycles after the turnaround. AD drives the write data with ad_oe high from the turnaround until the end of the hold phase.
- R5: In a read cycle (wr_nrd = 0) ad_oe is low from the turnaround until the end of the hold phase, and the read strobe is asserted for PULSE_CYC cycles after the turnaround.
- R6: Read data is the value on ad_i at the last clock edge of the read strobe. It appears on rdata when done is high and stays there until the next read completes.
- R7: After HOLD_CYC cycles with every strobe off except the latch, which stays deasserted, the bus returns to idle. The latch strobe is asserted, AD drives the address of the finished cycle, busy is low and done is high for exactly one cycle.
- R8: cfg_pol bit 0 sets the latch polarity, bit 1 sets the read polarity and bit 2 sets the write polarity. A bit value of 1 means the strobe is active high and 0 means active low.
- R9: cfg_en uses the same bit order as cfg_pol. When an enable bit is 0, that strobe stays at its idle level for the whole cycle. For the latch the idle level is asserted, and for read and write it is deasserted.
- R10: A request raised while busy is high is ignored and is not queued. The running cycle keeps its address and data, and no second cycle follows it.
- R11: The latch strobe is never asserted at the same time as the read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a bus cycle (taken only when idle) |
| wr_nrd | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 8 | Address for the cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Data captured by the last read |
| done | output | 1 | One-cycle pulse when a cycle ends |
| busy | output | 1 | High while a cycle is in progress |
| cfg_pol | input | 3 | Strobe polarity: bit 0 latch, bit 1 read, bit 2 write; 1 = active high |
| cfg_en | input | 3 | Strobe enable, same bit order as cfg_pol |
| ad_o | output | 8 | AD output value |
| ad_oe | output | 1 | AD output enable |
| ad_i | input | 8 | AD input value |
| ale_o | output | 1 | Address latch strobe pin |
| rd_o | output | 1 | Read strobe pin |
| wr_o | output | 1 | Write strobe pin |

## Verification
The bench builds the block with ADDR_CYC = 2, TURN_CYC = 1, PULSE_CYC = 3 and HOLD_CYC = 2, rather than the default 1/1/3/1. Because the phases have different lengths, a boundary that shifts by one cycle, or two phases that swap lengths, shows up at a distinct cycle. A three-cycle read pulse lets the bench change ad_i within the pulse, so a capture on any edge other than the last one returns the wrong byte. Random polarity and enable patterns cover all eight settings of each configuration vector across the run.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_TURN = 3'd2,
      PH_STRB = 3'd3,
      PH_HOLD = 3'd4
   } phase_e;

   localparam int unsigned SI_ALE = 0;
   localparam int unsigned SI_RD  = 1;
   localparam int unsigned SI_WR  = 2;
   localparam int unsigned N_STROBES = 3;
endpackage

// File: rtl/adbus_phase_timer.sv
module adbus_phase_timer #(
   parameter int unsigned CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len_m1,
   output logic          last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= len_m1;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

   // R2 R3 R4 R7: a running phase counts down by one each cycle until it ends
   a_r2_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adbus_strobe_drv.sv
module adbus_strobe_drv #(
   parameter bit IDLE_ASSERTED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic pol,
   input  logic en,
   output logic pin
);
   logic idle_lvl;

   generate
      if (IDLE_ASSERTED) begin : g_idle_on
         assign idle_lvl = pol;
      end else begin : g_idle_off
         assign idle_lvl = ~pol;
      end
   endgenerate

   assign pin = en ? (active ? pol : ~pol) : idle_lvl;

   // R9: a disabled strobe with steady configuration never moves
   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $stable(en) && $stable(pol) && $past(!en)) |-> $stable(pin));
endmodule

// File: rtl/adbus_master.sv
module adbus_master
   import adbus_pkg::*;
#(
   parameter int unsigned ADDR_CYC  = 1,
   parameter int unsigned TURN_CYC  = 1,
   parameter int unsigned PULSE_CYC = 3,
   parameter int unsigned HOLD_CYC  = 1,
   parameter int unsigned DW        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          wr_nrd,
   input  logic [DW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          done,
   output logic          busy,
   input  logic [2:0]    cfg_pol,
   input  logic [2:0]    cfg_en,
   output logic [DW-1:0] ad_o,
   output logic          ad_oe,
   input  logic [DW-1:0] ad_i,
   output logic          ale_o,
   output logic          rd_o,
   output logic          wr_o
);
   localparam int unsigned MAX_AT = (ADDR_CYC > TURN_CYC) ? ADDR_CYC : TURN_CYC;
   localparam int unsigned MAX_PH = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
   localparam int unsigned MAX_LEN = (MAX_AT > MAX_PH) ? MAX_AT : MAX_PH;
   localparam int unsigned CW = $clog2(MAX_LEN + 1);
   localparam logic [CW-1:0] A_M1 = CW'(ADDR_CYC - 1);
   localparam logic [CW-1:0] T_M1 = CW'(TURN_CYC - 1);
   localparam logic [CW-1:0] P_M1 = CW'(PULSE_CYC - 1);
   localparam logic [CW-1:0] H_M1 = CW'(HOLD_CYC - 1);

   generate
      if (ADDR_CYC < 1 || TURN_CYC < 1 || PULSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_len
         $error("adbus_master: every phase length must be at least one cycle");
      end
      if (DW < 1) begin : g_bad_dw
         $error("adbus_master: DW must be at least 1");
      end
   endgenerate

   phase_e        ph_q;
   logic          dir_q;
   logic [DW-1:0] addr_q, data_q, rdata_q;
   logic          done_q;
   logic          ld;
   logic [CW-1:0] ld_len;
   logic          ph_last;
   logic          accept;

   assign accept = (ph_q == PH_IDLE) && req;

   always_comb begin
      ld     = 1'b0;
      ld_len = A_M1;
      if (accept) begin
         ld = 1'b1;
         ld_len = A_M1;
      end else if (ph_last) begin
         unique case (ph_q)
            PH_ADDR: begin ld = 1'b1; ld_len = T_M1; end
            PH_TURN: begin ld = 1'b1; ld_len = P_M1; end
            PH_STRB: begin ld = 1'b1; ld_len = H_M1; end
            default: begin ld = 1'b0; ld_len = A_M1; end
         endcase
      end
   end

   adbus_phase_timer #(.CW(CW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ld),
      .len_m1 (ld_len),
      .last   (ph_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         dir_q   <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: if (req) begin
               ph_q   <= PH_ADDR;
               dir_q  <= wr_nrd;
               addr_q <= addr;
               data_q <= wdata;
            end
            PH_ADDR: if (ph_last) ph_q <= PH_TURN;
            PH_TURN: if (ph_last) ph_q <= PH_STRB;
            PH_STRB: if (ph_last) begin
               ph_q <= PH_HOLD;
               if (!dir_q) rdata_q <= ad_i;
            end
            PH_HOLD: if (ph_last) begin
               ph_q   <= PH_IDLE;
               done_q <= 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   logic addr_phase;
   logic [N_STROBES-1:0] act;
   logic [N_STROBES-1:0] pins;

   assign addr_phase   = (ph_q == PH_IDLE) || (ph_q == PH_ADDR);
   assign act[SI_ALE]  = addr_phase;
   assign act[SI_RD]   = (ph_q == PH_STRB) && !dir_q;
   assign act[SI_WR]   = (ph_q == PH_STRB) && dir_q;

   generate
      for (genvar s = 0; s < N_STROBES; s++) begin : g_strobe
         adbus_strobe_drv #(.IDLE_ASSERTED(s == SI_ALE)) u_drv (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (act[s]),
            .pol    (cfg_pol[s]),
            .en     (cfg_en[s]),
            .pin    (pins[s])
         );
      end
   endgenerate

   assign ale_o = pins[SI_ALE];
   assign rd_o  = pins[SI_RD];
   assign wr_o  = pins[SI_WR];
   assign ad_o  = addr_phase ? addr_q : data_q;
   assign ad_oe = addr_phase || dir_q;
   assign busy  = (ph_q != PH_IDLE);
   assign done  = done_q;
   assign rdata = rdata_q;

   // R11: latch and data strobes never overlap
   a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(act[SI_ALE] && (act[SI_RD] || act[SI_WR])));
   // R5: AD is released whenever the read strobe is active
   a_r5_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      act[SI_RD] |-> !ad_oe);
   // R7: done is a single-cycle pulse that coincides with idle
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));
   // R10: a busy block keeps the captured address
   a_r10_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req) |=> $stable(addr_q));
   // R6: read data changes only at the end of a read pulse
   a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph_q == PH_STRB && ph_last && !dir_q) |=> $stable(rdata_q));
endmodule

// File: tb/tb_adbus_master.sv
module tb_adbus_master;
   localparam int A = 2, T = 1, P = 3, H = 2;
   localparam int TOT = A + T + P + H;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, wr_nrd = 1'b0;
   logic [7:0] addr = '0, wdata = '0, ad_i = '0;
   logic [2:0] cfg_pol = 3'b001, cfg_en = 3'b111;
   logic [7:0] rdata, ad_o;
   logic done, busy, ad_oe, ale_o, rd_o, wr_o;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adbus_master #(.ADDR_CYC(A), .TURN_CYC(T), .PULSE_CYC(P), .HOLD_CYC(H)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .wr_nrd(wr_nrd), .addr(addr),
      .wdata(wdata), .rdata(rdata), .done(done), .busy(busy),
      .cfg_pol(cfg_pol), .cfg_en(cfg_en), .ad_o(ad_o), .ad_oe(ad_oe),
      .ad_i(ad_i), .ale_o(ale_o), .rd_o(rd_o), .wr_o(wr_o));

   function automatic logic lvl(logic asrt, logic pol, logic en, logic idle_on);
      if (!en) return idle_on ? pol : ~pol;
      return asrt ? pol : ~pol;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_idle(logic [7:0] a);
      chk("R1/R7 ale idle", ale_o, lvl(1'b1, cfg_pol[0], cfg_en[0], 1'b1));
      chk("R1/R9 rd idle", rd_o, lvl(1'b0, cfg_pol[1], cfg_en[1], 1'b0));
      chk("R1/R9 wr idle", wr_o, lvl(1'b0, cfg_pol[2], cfg_en[2], 1'b0));
      chk("R1/R7 ad_oe idle", ad_oe, 1);
      chk("R1/R7 ad_o idle", ad_o, a);
      chk("R1/R10 busy idle", busy, 0);
   endtask

   task automatic run_txn(logic w, logic [7:0] a, logic [7:0] d, logic [7:0] rv, bit poke);
      int ph;
      logic al, rs, ws;
      @(negedge clk);
      req = 1'b1; wr_nrd = w; addr = a; wdata = d; ad_i = ~rv;
      @(negedge clk);
      req = 1'b0;
      for (int k = 0; k < TOT; k++) begin
         ph = (k < A) ? 0 : (k < A + T) ? 1 : (k < A + T + P) ? 2 : 3;
         al = (ph == 0);
         rs = (ph == 2) && !w;
         ws = (ph == 2) && w;
         chk("R2 busy", busy, 1);
         chk("R7 done low mid-cycle", done, 0);
         chk("R3/R8/R9/R11 ale", ale_o, lvl(al, cfg_pol[0], cfg_en[0], 1'b1));
         chk("R5/R8/R9/R11 rd", rd_o, lvl(rs, cfg_pol[1], cfg_en[1], 1'b0));
         chk("R4/R8/R9/R11 wr", wr_o, lvl(ws, cfg_pol[2], cfg_en[2], 1'b0));
         if (ph == 0) begin
            chk("R2 ad_oe addr", ad_oe, 1);
            chk("R2/R10 ad_o addr", ad_o, a);
         end else if (w) begin
            chk("R4 ad_oe write", ad_oe, 1);
            chk("R4/R10 ad_o data", ad_o, d);
         end else begin
            chk("R5 ad_oe read", ad_oe, 0);
         end
         if (poke && k == 1) begin
            req = 1'b1; addr = ~a; wdata = ~d; wr_nrd = ~w;
         end
         if (k == TOT - 1) req = 1'b0;
         if (ph == 2 && k == A + T + P - 1) ad_i = rv;
         else if (ph == 2) ad_i = rv ^ 8'h5A ^ 8'(k);
         else ad_i = ~rv;
         @(negedge clk);
      end
      chk("R7 done pulse", done, 1);
      chk_idle(a);
      if (!w) chk("R6 rdata", rdata, rv);
      @(negedge clk);
      chk("R7 done single", done, 0);
      chk("R10 no second cycle", busy, 0);
      chk("R7 ad_o after", ad_o, a);
   endtask

   initial begin
      void'($urandom(32'd1729));
      #35 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done reset", done, 0);
      chk_idle(8'h00);
      run_txn(1'b1, 8'hA5, 8'h3C, 8'h00, 1'b0);
      run_txn(1'b0, 8'h00, 8'h00, 8'hFF, 1'b0);
      run_txn(1'b0, 8'hFF, 8'h11, 8'h96, 1'b1);
      run_txn(1'b1, 8'h7E, 8'hFF, 8'h00, 1'b1);
      cfg_pol = 3'b110; cfg_en = 3'b111;
      run_txn(1'b0, 8'h12, 8'h34, 8'h56, 1'b0);
      run_txn(1'b1, 8'h12, 8'h34, 8'h56, 1'b0);
      cfg_pol = 3'b001; cfg_en = 3'b101;
      run_txn(1'b0, 8'h21, 8'h00, 8'hC3, 1'b0);
      cfg_en = 3'b010;
      run_txn(1'b1, 8'h42, 8'h81, 8'h00, 1'b0);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         cfg_pol = 3'($urandom);
         cfg_en  = 3'($urandom);
         run_txn(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule